// File: doc/BRIEF.md
# Weighted Scan Shift Transition Counter

This block sizes the switching cost of loading or unloading one scan vector. It watches the serial stream fed to (or leaving) a scan chain of `m` cells and adds up a weighted count of bit changes. A change between two bits that are shifted one after the other does not stay in one cell. It ripples down the chain for every shift cycle still to come in that vector. Each change is therefore weighted by the number of cells it will disturb.

In scan-in mode, a change between the k-th and (k+1)-th shifted bits is weighted `m - k`. This is because the change enters at the head of the chain and keeps travelling. In scan-out mode, bits leave from the tail, so the weighting runs the other way and the same change is weighted `k`. A control state machine takes the chain length and the mode at the first bit of every vector. It counts only the cycles that carry a valid bit. After the m-th bit it issues the total with a one-cycle strobe, then waits for the next vector.

The state machine has two states. `ST_WAIT` waits for the first bit of a vector. `ST_SHIFT` accumulates the rest of the vector. Its transitions are:
- T_START (`ST_WAIT`→`ST_SHIFT`): the first bit arrives and the length is above 1.
- T_SINGLE (`ST_WAIT`→`ST_WAIT`): the first bit completes a one-cell vector.
- T_STEP (`ST_SHIFT`→`ST_SHIFT`): an interior bit.
- T_LAST (`ST_SHIFT`→`ST_WAIT`): the m-th bit.
- T_HOLD: any cycle with no valid bit; the state does not change.

Top module: `scan_shift_weight`

## Requirements
- R1: A weight is added only when a valid bit differs from the previous valid bit of the same vector; runs of equal bits add nothing.
- R2: With `dir_sel` = 0 (scan-in), a change between shifted bits k and k+1 (1-based, k = 1 … m−1) adds `m − k`.
- R3: With `dir_sel` = 1 (scan-out), a change between shifted bits k and k+1 adds `k`.
- R4: The total clears at the first bit of each vector. The first bit of a vector is never compared with the last bit of the vector before it, even when the two vectors are back to back.
- R5: The clock edge that samples the m-th valid bit sets `count_vld` high for exactly one cycle, with the total on `count`. `count` then holds its value until the next vector ends.
- R6: Cycles with `shift_vld` low are ignored. They do not advance the bit position, their `bit_in` is not used, and in the following cycle `count_vld` is low and `count` is unchanged.
- R7: `chain_len` and `dir_sel` are taken at the first bit of a vector. Changes to them later in the vector have no effect on that vector.
- R8: The effective length is `chain_len` limited to the range 1 … MAX_LEN. A length of 1 (or 0) gives a total of 0 on the same edge as its single bit. A value above MAX_LEN acts as MAX_LEN.
- R9: The total cannot overflow. A fully alternating vector of length MAX_LEN gives MAX_LEN·(MAX_LEN−1)/2 (2016 for the default of 64) in either mode.
- R10: After reset, `count_vld` is 0, `count` is 0, and the block waits for the first bit of a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial scan bit |
| shift_vld | input | 1 | High in cycles that carry a valid shift bit |
| dir_sel | input | 1 | 0 = scan-in weighting, 1 = scan-out weighting |
| chain_len | input | LEN_W (7) | Chain length `m` for the next vector |
| count | output | ACC_W (11) | Weighted transition total of the last finished vector |
| count_vld | output | 1 | One-cycle strobe marking a new total |

## Verification
A bit position that drifts shows up at the ports within one vector. The strobe then arrives early or late, or a total is computed with weights shifted by one, and it appears at the end of the affected vector. A stale previous bit or an uncleared total corrupts the very next result, most clearly when two vectors are back to back. A mode or length register that is updated during a vector changes that vector's total as soon as it ends. The scoreboard therefore checks every total and every strobe against values the bench computes itself, and flags any strobe it did not expect.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic {
        ST_WAIT  = 1'b0,
        ST_SHIFT = 1'b1
    } wtc_state_e;

endpackage

// File: rtl/wtc_edge_detect.sv
module wtc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic bit_in,
    output logic prev_bit,
    output logic differs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_bit <= 1'b0;
        end else if (take) begin
            prev_bit <= bit_in;
        end
    end

    assign differs = bit_in ^ prev_bit;

endmodule

// File: rtl/wtc_weight_sel.sv
module wtc_weight_sel #(
    parameter int LEN_W = 7,
    parameter int ACC_W = 11
) (
    input  logic             unload,
    input  logic [LEN_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    output logic [ACC_W-1:0] weight
);

    logic [LEN_W-1:0] raw;

    // Scan-in: a change still travels (len - pos) cells; scan-out: pos cells.
    always_comb begin
        if (unload) begin
            raw = pos;
        end else begin
            raw = len - pos;
        end
        weight = ACC_W'(raw);
    end

endmodule

// File: rtl/wtc_accum.sv
module wtc_accum #(
    parameter int ACC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] sum_q,
    output logic [ACC_W-1:0] sum_next
);

    always_comb begin
        if (clear) begin
            sum_next = '0;
        end else if (add_en) begin
            sum_next = sum_q + addend;
        end else begin
            sum_next = sum_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_next;
        end
    end

endmodule

// File: rtl/scan_shift_weight.sv
module scan_shift_weight #(
    parameter int MAX_LEN   = 64,
    parameter int LEN_W     = $clog2(MAX_LEN + 1),
    parameter int ACC_W_MIN = $clog2((MAX_LEN * (MAX_LEN - 1)) / 2 + 1),
    parameter int ACC_W     = (ACC_W_MIN > LEN_W) ? ACC_W_MIN : LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             shift_vld,
    input  logic             dir_sel,
    input  logic [LEN_W-1:0] chain_len,
    output logic [ACC_W-1:0] count,
    output logic             count_vld
);

    import wtc_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    wtc_state_e       state_q;
    wtc_state_e       state_d;
    logic [LEN_W-1:0] len_q;
    logic             dir_q;
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] len_eff;

    logic             prev_bit;
    logic             differs;
    logic [ACC_W-1:0] weight;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;

    logic             first_bit;
    logic             inner_bit;
    logic             last_bit;

    // Clamp the requested length into 1 .. MAX_LEN.
    always_comb begin
        if (chain_len == '0) begin
            len_eff = LEN_ONE;
        end else if (chain_len > LEN_MAX) begin
            len_eff = LEN_MAX;
        end else begin
            len_eff = chain_len;
        end
    end

    // Next-state and event decode.
    always_comb begin
        state_d   = state_q;
        first_bit = 1'b0;
        inner_bit = 1'b0;
        last_bit  = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (shift_vld) begin
                    first_bit = 1'b1;
                    if (len_eff == LEN_ONE) begin
                        last_bit = 1'b1;      // T_SINGLE
                    end else begin
                        state_d = ST_SHIFT;   // T_START
                    end
                end
            end
            ST_SHIFT: begin
                if (shift_vld) begin
                    inner_bit = 1'b1;
                    if (pos_q + LEN_ONE == len_q) begin
                        last_bit = 1'b1;
                        state_d  = ST_WAIT;   // T_LAST
                    end                       // else T_STEP
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Vector context: length, mode and bit position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_ONE;
            dir_q <= 1'b0;
            pos_q <= '0;
        end else if (first_bit) begin
            len_q <= len_eff;
            dir_q <= dir_sel;
            pos_q <= LEN_ONE;
        end else if (inner_bit) begin
            pos_q <= last_bit ? '0 : pos_q + LEN_ONE;
        end
    end

    wtc_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (shift_vld),
        .bit_in   (bit_in),
        .prev_bit (prev_bit),
        .differs  (differs)
    );

    wtc_weight_sel #(
        .LEN_W (LEN_W),
        .ACC_W (ACC_W)
    ) u_weight (
        .unload (dir_q),
        .pos    (pos_q),
        .len    (len_q),
        .weight (weight)
    );

    wtc_accum #(
        .ACC_W (ACC_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (first_bit),
        .add_en   (inner_bit & differs),
        .addend   (weight),
        .sum_q    (acc_q),
        .sum_next (acc_next)
    );

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            count_vld <= 1'b0;
        end else begin
            count_vld <= last_bit;
            if (last_bit) begin
                count <= acc_next;
            end
        end
    end

endmodule

// File: rtl/scan_shift_weight_chk.sv
module scan_shift_weight_chk #(
    parameter int LEN_W = 7,
    parameter int ACC_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_vld,
    input  logic              bit_in,
    input  logic              count_vld,
    input  logic [ACC_W-1:0]  count,
    input  wtc_pkg::wtc_state_e state_q,
    input  logic [LEN_W-1:0]  pos_q,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              prev_bit,
    input  logic [ACC_W-1:0]  acc_q
);

    import wtc_pkg::*;

    // R6: an empty cycle produces no result and keeps the last total.
    a_r6_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_vld |=> !count_vld);

    a_r6_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_vld |=> $stable(count));

    // R1: equal successive bits leave the running total untouched.
    a_r1_equal_no_add: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && shift_vld && bit_in == prev_bit) |=> $stable(acc_q));

    // R7: length stays fixed while a vector is being shifted.
    a_r7_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |=> (state_q == ST_WAIT || $stable(len_q)));

    // R5: the bit position stays inside the vector.
    a_r5_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (pos_q != '0 && pos_q < len_q));

    // R9: the running total never exceeds m(m-1)/2.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |->
            (2 * int'(acc_q) <= int'(len_q) * (int'(len_q) - 1)));

endmodule

bind scan_shift_weight scan_shift_weight_chk #(
    .LEN_W (LEN_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_vld (shift_vld),
    .bit_in    (bit_in),
    .count_vld (count_vld),
    .count     (count),
    .state_q   (state_q),
    .pos_q     (pos_q),
    .len_q     (len_q),
    .prev_bit  (prev_bit),
    .acc_q     (acc_q)
);

// File: tb/scan_shift_weight_bench.sv
module scan_shift_weight_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 64;
    localparam int LEN_W      = 7;
    localparam int ACC_W      = 11;

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_in = 1'b0;
    logic             shift_vld = 1'b0;
    logic             dir_sel = 1'b0;
    logic [LEN_W-1:0] chain_len = '0;
    logic [ACC_W-1:0] count;
    logic             count_vld;

    int   n_checks = 0;
    int   n_bad    = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_shift_weight #(.MAX_LEN(MAX_LEN)) u_scan_shift_weight (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .shift_vld (shift_vld),
        .dir_sel   (dir_sel),
        .chain_len (chain_len),
        .count     (count),
        .count_vld (count_vld)
    );

    function automatic void check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    function automatic int eff_len(int len);
        if (len < 1) return 1;
        if (len > MAX_LEN) return MAX_LEN;
        return len;
    endfunction

    // Expected total from the weighting rules (R2, R3).
    function automatic int exp_total(int len, bit unload, logic [63:0] b);
        int m;
        int sum;
        m = eff_len(len);
        sum = 0;
        for (int k = 1; k < m; k++) begin
            if (b[k-1] != b[k]) sum += unload ? k : (m - k);
        end
        return sum;
    endfunction

    task automatic drive(logic b, logic v);
        @(negedge clk);
        bit_in    = b;
        shift_vld = v;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
    endtask

    // Driver: queue the expected total, then shift the vector (bit 0 first).
    task automatic send_vec(int len, bit unload, logic [63:0] b,
                            bit gaps, bit scramble, string tag);
        exp_t e;
        int   m;
        m     = eff_len(len);
        e.val = exp_total(len, unload, b);
        e.tag = tag;
        sb_q.push_back(e);
        for (int i = 0; i < m; i++) begin
            if (gaps && i > 0) drive(~b[i], 1'b0);
            @(negedge clk);
            bit_in    = b[i];
            shift_vld = 1'b1;
            if (i == 0) begin
                chain_len = LEN_W'(len);
                dir_sel   = unload;
            end else if (scramble) begin
                chain_len = LEN_W'(3);
                dir_sel   = ~unload;
            end
        end
    endtask

    // Monitor: every strobe must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && count_vld && !done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", int'(count), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(int'(count) == e.val, e.tag, int'(count), e.val);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(count_vld == 1'b0, "R10 vld after reset", int'(count_vld), 0);
        check(count == '0, "R10 count after reset", int'(count), 0);
        rst_n = 1'b1;
        idle(2);
        check(count_vld == 1'b0, "R10 idle no strobe", int'(count_vld), 0);

        // R5: strobe timing and hold
        send_vec(8, 1'b0, 64'h01, 1'b0, 1'b0, "R5 R2 change at k=1 scan-in");
        @(posedge clk); #1;
        check(count_vld == 1'b1, "R5 strobe after last bit", int'(count_vld), 1);
        held = int'(count);
        @(negedge clk);
        shift_vld = 1'b0;
        @(posedge clk); #1;
        check(count_vld == 1'b0, "R5 strobe one cycle", int'(count_vld), 0);
        check(int'(count) == held, "R5 count held", int'(count), held);
        idle(2);

        // R2 / R3 weighting direction
        send_vec(8, 1'b0, 64'h80, 1'b0, 1'b0, "R2 change at k=7 scan-in");
        send_vec(8, 1'b1, 64'h01, 1'b0, 1'b0, "R3 change at k=1 scan-out");
        send_vec(8, 1'b1, 64'h80, 1'b0, 1'b0, "R3 change at k=7 scan-out");
        // R1: runs and mixed pattern
        send_vec(8, 1'b0, 64'h00, 1'b0, 1'b0, "R1 all zeros");
        send_vec(8, 1'b1, 64'hFF, 1'b0, 1'b0, "R1 all ones");
        send_vec(8, 1'b0, 64'h33, 1'b0, 1'b0, "R1 pairs scan-in");
        send_vec(8, 1'b1, 64'h33, 1'b0, 1'b0, "R1 pairs scan-out");
        // R4: back to back, last bit 1 then a vector of zeros
        send_vec(4, 1'b0, 64'h8, 1'b0, 1'b0, "R4 first vector");
        send_vec(4, 1'b0, 64'h0, 1'b0, 1'b0, "R4 no cross-vector compare");
        send_vec(5, 1'b1, 64'h1E, 1'b0, 1'b0, "R4 third vector");
        idle(3);
        // R6: empty cycles with junk bits in between
        send_vec(8, 1'b0, 64'h01, 1'b1, 1'b0, "R6 gaps scan-in");
        send_vec(9, 1'b1, 64'h155, 1'b1, 1'b0, "R6 gaps scan-out");
        // R7: mode and length changed mid-vector
        send_vec(8, 1'b0, 64'h01, 1'b0, 1'b1, "R7 scrambled controls");
        send_vec(10, 1'b1, 64'h2A5, 1'b0, 1'b1, "R7 scrambled scan-out");
        // R8: length corners
        send_vec(1, 1'b0, 64'h1, 1'b0, 1'b0, "R8 length one");
        send_vec(0, 1'b1, 64'h0, 1'b0, 1'b0, "R8 length zero");
        send_vec(2, 1'b0, 64'h2, 1'b0, 1'b0, "R8 length two");
        send_vec(100, 1'b0, 64'h5555_5555_5555_5555, 1'b0, 1'b0, "R8 length clamped");
        // R9: largest totals
        send_vec(64, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b0, "R9 max scan-in");
        send_vec(64, 1'b1, 64'h5555_5555_5555_5555, 1'b0, 1'b0, "R9 max scan-out");
        idle(4);
        check(sb_q.size() == 0, "R5 missing strobes", sb_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule